// File: doc/BRIEF.md
# SPI Master Byte Shifter

This block is a register-mapped serial master that moves one byte out on MOSI while collecting one byte from MISO. Software programs a control register (enable, master mode, interrupt enable, bit order, clock polarity, clock phase, clock rate), then writes a byte to the data register. That write alone launches a transfer: the serial clock runs for exactly eight periods and then parks at its idle level, the completion flag rises and, when enabled, an interrupt request follows.

Slave-select is not driven here at all; software asserts and releases it through a general-purpose output around each transfer. The transmit side has no holding buffer, so a data write during a shift is dropped and reported through a collision flag. The received byte sits in a read buffer until the next transfer completes.

Register map (addr_i): 0 = control, 1 = status, 2 = data (write: transmit byte, read: received byte), 3 reads zero. Control bits: [7] interrupt enable, [6] enable, [5] LSB first, [4] master, [3] CPOL, [2] CPHA, [1:0] rate. Status bits: [7] done flag, [6] write collision, others zero.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, control, status and data read as 0x00, sck_o is 0 and irq_o is 0.
- R2: A data write (addr 2) while enabled (ctrl[6]=1), master (ctrl[4]=1) and idle shifts out the written byte on mosi_o and collects 8 bits from miso_i, with exactly 16 SCK edges.
- R3: With H = 4^ctrl[1:0] system cycles, SCK toggles H, 2H, ... 16H cycles after the clock edge that accepts the data write, then stays at its idle level; status[7] reads 1 from cycle 16H+1 on.
- R4: irq_o is 1 exactly when status[7] and ctrl[7] are both 1.
- R5: A data write while a transfer is in progress does not alter the byte being shifted and sets status[6].
- R6: The data register reads the byte received in the last completed transfer, unchanged during a following transfer until it completes.
- R7: miso_dir_o is 1 (MISO forced to input) exactly when ctrl[6] and ctrl[4] are both 1.
- R8: Idle SCK equals ctrl[3]. With ctrl[2]=0, MISO is sampled on the leading edge and MOSI changes on the trailing edge; with ctrl[2]=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R9: status[7] and status[6] clear on the first data-register access after a status read that saw status[7]=1; a data access without that prior status read clears nothing.
- R10: ctrl[5]=0 shifts bit 7 first; ctrl[5]=1 shifts bit 0 first, in both directions.
- R11: A data write while not both enabled and master starts no transfer: SCK does not toggle and status[7] stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| miso_dir_o | output | 1 | Forces the MISO pad to input when 1 |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions watch, on every cycle, that the transmit byte holds steady through a shift, that a colliding write always raises the collision flag, that completion raises the done flag on the next cycle, that SCK stays quiet while idle, and that a transfer only begins with MISO forced to input. Correct bit order, correct sampling edge per CPHA setting, the exact SCK timing per rate, the read-then-access clearing sequence and the ignored writes outside master mode are only shown by the bench scenarios, where a behavioural slave exchanges bytes with the block and a cycle-counting model predicts SCK, irq_o and miso_dir_o on every clock.

// File: rtl/spi_byte_master_pkg.sv
package spi_byte_master_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned RATE_W  = 2;
  localparam int unsigned BIT_W   = $clog2(DW);
  localparam int unsigned EDGE_W  = BIT_W + 1;
  localparam int unsigned CNT_W   = 2 * ((1 << RATE_W) - 1);

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int unsigned C_IE   = 7;
  localparam int unsigned C_EN   = 6;
  localparam int unsigned C_LSB  = 5;
  localparam int unsigned C_MST  = 4;
  localparam int unsigned C_CPOL = 3;
  localparam int unsigned C_CPHA = 2;

  typedef struct packed {
    logic              cpol;
    logic              cpha;
    logic              lsb;
    logic [RATE_W-1:0] rate;
  } cfg_t;
endpackage

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_byte_master_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] half_m1;

  // half period = 4^rate cycles
  always_comb begin
    half_m1 = CNT_W'((32'd1 << {rate_i, 1'b0}) - 32'd1);
    tick_o  = run_i && (cnt_q == half_m1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_byte_master_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  cfg_t          cfg_i,
  input  logic          tick_i,
  input  logic          miso_i,
  output cfg_t          cfg_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          sck_o,
  output logic          mosi_o,
  output logic [DW-1:0] rx_o
);
  cfg_t              cfg_q;
  logic              busy_q, done_q, sck_q, out_q;
  logic [DW-1:0]     tx_q, rx_q;
  logic [EDGE_W-1:0] edg_q;
  logic [BIT_W-1:0]  k, k_nxt, pos_cur, pos_nxt, pos_first;
  logic              leading, last_edge;

  always_comb begin
    k         = edg_q[EDGE_W-1:1];
    k_nxt     = k + 1'b1;
    leading   = ~edg_q[0];
    last_edge = (edg_q == EDGE_W'(2*DW-1));
    pos_cur   = cfg_q.lsb ? k     : BIT_W'(DW-1) - k;
    pos_nxt   = cfg_q.lsb ? k_nxt : BIT_W'(DW-1) - k_nxt;
    pos_first = cfg_i.lsb ? '0    : BIT_W'(DW-1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sck_q  <= 1'b0;
      out_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      edg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        cfg_q  <= cfg_i;
        tx_q   <= data_i;
        rx_q   <= '0;
        edg_q  <= '0;
        sck_q  <= cfg_i.cpol;
        out_q  <= data_i[pos_first];
      end else if (busy_q && tick_i) begin
        sck_q <= ~sck_q;
        edg_q <= edg_q + 1'b1;
        if (leading) begin
          if (!cfg_q.cpha) rx_q[pos_cur] <= miso_i;
          else             out_q <= tx_q[pos_cur];
        end else begin
          if (!cfg_q.cpha) begin
            if (k != BIT_W'(DW-1)) out_q <= tx_q[pos_nxt];
          end else begin
            rx_q[pos_cur] <= miso_i;
          end
        end
        if (last_edge) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign cfg_o  = cfg_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign sck_o  = sck_q;
  assign mosi_o = out_q;
  assign rx_o   = rx_q;
endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_byte_master_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          done_i,
  input  logic [DW-1:0] rx_i,
  output cfg_t          cfg_o,
  output logic          master_on_o,
  output logic          start_o,
  output logic          irq_o,
  output logic          flag_o,
  output logic          wcol_o
);
  logic [DW-1:0] ctrl_q, rxbuf_q;
  logic          flag_q, wcol_q, armed_q;
  logic          wr_data, acc_data, rd_stat, clr, coll;

  always_comb begin
    wr_data     = req_i && we_i && (addr_i == A_DATA);
    acc_data    = req_i && (addr_i == A_DATA);
    rd_stat     = req_i && !we_i && (addr_i == A_STAT);
    clr         = acc_data && armed_q;
    master_on_o = ctrl_q[C_EN] && ctrl_q[C_MST];
    coll        = wr_data && busy_i;
    start_o     = wr_data && !busy_i && master_on_o;
    cfg_o       = '{cpol: ctrl_q[C_CPOL], cpha: ctrl_q[C_CPHA],
                    lsb:  ctrl_q[C_LSB],  rate: ctrl_q[RATE_W-1:0]};
    irq_o       = flag_q && ctrl_q[C_IE];
    flag_o      = flag_q;
    wcol_o      = wcol_q;
    unique case (addr_i)
      A_CTRL:  rdata_o = ctrl_q;
      A_STAT:  rdata_o = {flag_q, wcol_q, {(DW-2){1'b0}}};
      A_DATA:  rdata_o = rxbuf_q;
      default: rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      rxbuf_q <= '0;
      flag_q  <= 1'b0;
      wcol_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (req_i && we_i && (addr_i == A_CTRL)) ctrl_q <= wdata_i;
      if (done_i) rxbuf_q <= rx_i;
      if (done_i)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (coll)     wcol_q <= 1'b1;
      else if (clr) wcol_q <= 1'b0;
      if (clr)                    armed_q <= 1'b0;
      else if (rd_stat && flag_q) armed_q <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_master_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          sck_o,
  output logic          mosi_o,
  input  logic          miso_i,
  output logic          miso_dir_o,
  output logic          irq_o
);
  cfg_t          cfg_reg, cfg_run;
  logic          start, busy, done, tick, sck_raw, master_on, flag, wcol;
  logic [DW-1:0] rx;

  spi_reg_file u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .busy_i(busy), .done_i(done), .rx_i(rx),
    .cfg_o(cfg_reg), .master_on_o(master_on), .start_o(start),
    .irq_o, .flag_o(flag), .wcol_o(wcol)
  );

  spi_rate_gen u_rate (
    .clk_i, .rst_ni, .run_i(busy), .rate_i(cfg_run.rate), .tick_o(tick)
  );

  spi_shift_engine u_eng (
    .clk_i, .rst_ni, .start_i(start), .data_i(wdata_i), .cfg_i(cfg_reg),
    .tick_i(tick), .miso_i, .cfg_o(cfg_run), .busy_o(busy), .done_o(done),
    .sck_o(sck_raw), .mosi_o, .rx_o(rx)
  );

  assign sck_o      = busy ? sck_raw : cfg_reg.cpol;
  assign miso_dir_o = master_on;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_byte_master_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [1:0]    addr_i,
  input logic          busy,
  input logic          done,
  input logic          flag,
  input logic          wcol,
  input logic          sck_o,
  input logic          cpol,
  input logic          miso_dir_o,
  input logic [DW-1:0] tx_q
);
  logic wr_data;
  assign wr_data = req_i && we_i && (addr_i == A_DATA);

  p_flag_after_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> flag);
  p_done_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |-> !busy);
  p_wcol_set_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_data && busy) |=> wcol);
  p_tx_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(tx_q));
  p_sck_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !$past(busy) && $stable(cpol)) |-> $stable(sck_o));
  p_start_dir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> miso_dir_o);
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
  .busy(busy), .done(done), .flag(flag), .wcol(wcol),
  .sck_o, .cpol(cfg_reg.cpol), .miso_dir_o, .tx_q(u_eng.tx_q)
);

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       req_i = 1'b0, we_i = 1'b0, miso_i = 1'b0;
  logic [1:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       sck_o, mosi_o, miso_dir_o, irq_o;

  always #4 clk_i = ~clk_i;

  spi_byte_master u0 (.*);

  int checks = 0, errors = 0;

  // model state
  logic [7:0] m_ctrl = '0;
  bit  m_flag = 0, m_wcol = 0, m_arm = 0, act = 0;
  int  k = 0, h = 1;
  bit  l_cpol = 0, l_cpha = 0, l_lsb = 0;
  // slave
  logic [7:0] slv_tx = '0, slv_rx = '0;
  int  slv_edge = 0;
  bit  prev_sck = 0;

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  function automatic int bpos(input bit lsb, input int i);
    return lsb ? i : 7 - i;
  endfunction

  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      bit hit, busy_m, fl_old;
      hit    = req_i && we_i && addr_i == 2'd2;
      busy_m = act && k < 16*h;
      fl_old = m_flag;
      if (act) k++;
      if (act && k == 16*h + 1) m_flag = 1;
      if (req_i && addr_i == 2'd2 && m_arm) begin
        if (!(act && k == 16*h + 1)) m_flag = 0;
        m_wcol = 0;
        m_arm  = 0;
      end else if (req_i && !we_i && addr_i == 2'd1 && fl_old) m_arm = 1;
      if (hit && busy_m) m_wcol = 1;
      if (hit && !busy_m && m_ctrl[6] && m_ctrl[4]) begin
        act = 1; k = 0;
        l_cpol = m_ctrl[3]; l_cpha = m_ctrl[2]; l_lsb = m_ctrl[5];
        h = 1 << (2*m_ctrl[1:0]);
        slv_edge = 0; slv_rx = '0; prev_sck = l_cpol;
        if (!l_cpha) miso_i = slv_tx[bpos(l_lsb, 0)];
      end
      if (req_i && we_i && addr_i == 2'd0) m_ctrl = wdata_i;
      // slave reacts to SCK edges
      if (act && k > 0 && k <= 16*h && sck_o !== prev_sck) begin
        int kk;
        kk = slv_edge / 2;
        if (slv_edge % 2 == 0) begin
          if (!l_cpha) slv_rx[bpos(l_lsb, kk)] = mosi_o;
          else         miso_i = slv_tx[bpos(l_lsb, kk)];
        end else begin
          if (!l_cpha) begin
            if (kk < 7) miso_i = slv_tx[bpos(l_lsb, kk+1)];
          end else slv_rx[bpos(l_lsb, kk)] = mosi_o;
        end
        slv_edge++;
        prev_sck = sck_o;
      end
      // per-clock comparison
      if (act && k < 16*h) chk("R3 R8 sck", sck_o, l_cpol ^ ((k/h) & 1));
      else                 chk("R8 idle sck", sck_o, m_ctrl[3]);
      chk("R4 irq", irq_o, m_flag & m_ctrl[7]);
      chk("R7 miso dir", miso_dir_o, m_ctrl[6] & m_ctrl[4]);
    end
  end

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 0;
  endtask

  task automatic xfer(input logic [7:0] c, input logic [7:0] mb, input logic [7:0] sb,
                      input string req);
    bus_wr(2'd0, c);
    slv_tx = sb;
    bus_wr(2'd2, mb);
    repeat (16 * (1 << (2*c[1:0])) + 4) @(negedge clk_i);
    chk({req, " slave got"}, slv_rx, mb);
    chk("R2 edge count", slv_edge, 16);
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 sck", sck_o, 0);
    chk("R1 irq", irq_o, 0);
    rst_ni = 1;
    bus_rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    bus_rd(2'd1, d); chk("R1 stat", d, 8'h00);
    bus_rd(2'd2, d); chk("R1 data", d, 8'h00);

    // mode 0, rate 0, MSB first
    xfer(8'h50, 8'hA5, 8'h3C, "R2 R10");
    bus_rd(2'd1, d); chk("R3 flag", d, 8'h80);
    bus_rd(2'd2, d); chk("R6 rx byte", d, 8'h3C);
    bus_rd(2'd1, d); chk("R9 cleared", d, 8'h00);

    // mode 3, rate 1, LSB first
    xfer(8'h7D, 8'h6B, 8'h1E, "R8 R10");
    chk("R8 idle high", sck_o, 1);
    bus_rd(2'd2, d); chk("R10 lsb rx", d, 8'h1E);
    bus_rd(2'd1, d); chk("R9 no clear w/o status", d, 8'h80);
    bus_rd(2'd2, d);
    bus_rd(2'd1, d); chk("R9 cleared", d, 8'h00);

    // mode 1, rate 2, irq, collision
    bus_wr(2'd0, 8'hD6);
    slv_tx = 8'h5A;
    bus_wr(2'd2, 8'hC3);
    repeat (20) @(negedge clk_i);
    bus_rd(2'd2, d); chk("R6 held during xfer", d, 8'h1E);
    bus_wr(2'd2, 8'h00);
    repeat (16*16) @(negedge clk_i);
    chk("R5 shifted byte intact", slv_rx, 8'hC3);
    chk("R4 irq up", irq_o, 1);
    bus_rd(2'd1, d); chk("R5 wcol+flag", d, 8'hC0);
    bus_rd(2'd2, d); chk("R8 cpha1 rx", d, 8'h5A);
    chk("R4 irq down", irq_o, 0);
    bus_rd(2'd1, d); chk("R9 both cleared", d, 8'h00);

    // mode 2, rate 3
    xfer(8'h5B, 8'h96, 8'h69, "R3 R8");
    bus_rd(2'd1, d); bus_rd(2'd2, d); chk("R8 mode2 rx", d, 8'h69);

    // R11 not master / not enabled
    bus_wr(2'd0, 8'h40);
    chk("R7 dir off", miso_dir_o, 0);
    slv_edge = 0;
    bus_wr(2'd2, 8'hFF);
    repeat (20) @(negedge clk_i);
    bus_rd(2'd1, d); chk("R11 no flag (en only)", d, 8'h00);
    bus_wr(2'd0, 8'h10);
    bus_wr(2'd2, 8'hFF);
    repeat (20) @(negedge clk_i);
    bus_rd(2'd1, d); chk("R11 no flag (master only)", d, 8'h00);
    chk("R11 no edges", slv_edge, 0);
    bus_rd(2'd2, d); chk("R6 rx kept", d, 8'h69);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule